// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is a first-in first-out store of 256 words of 36 bits that sits between two unrelated clock domains. The producer pushes words on the write clock, and the consumer pops them on the read clock. The read word comes out of a register. Each side keeps its own binary pointer. The pointer travels to the opposite side as Gray code through a two-stage synchronizer, and each side works out a fill level from its own pointer and the synchronized copy of the other.

Five status flags report the fill level. On the write clock they are full, almost-full and half-full. On the read clock they are empty and almost-empty. A flag that is set by the side's own traffic rises on a rising clock edge. When traffic from the other side makes it untrue, it drops on the following falling edge of its own clock.

Two offset registers set the thresholds for almost-full and almost-empty. A small configuration port on the write clock loads both offsets at once or one at a time. Each offset is 8 after reset and can take any value from 0 to 255. The offsets are meant to be changed only while no words are moving.

Top module: `dcfifo_flags`

## Requirements
- R1: After reset, empty and almost_empty read 1, full, almost_full and half_full read 0, and rd_data reads 0.
- R2: Words come out in the order they went in. rd_data takes the oldest stored word on the rclk rising edge at which rd_en is sampled high with the FIFO not empty, and holds its value otherwise.
- R3: A write sampled while the write-side level is 256 is dropped. It does not alter any stored word or the write position.
- R4: A read sampled while the read-side level is 0 is dropped. rd_data keeps its value and the read position does not move, so the next word written is the next word read.
- R5: full rises on the wclk rising edge of the write that brings the write-side level to 256. Once a read has lowered that level, full falls on a wclk falling edge.
- R6: empty rises on the rclk rising edge of the read that takes the last word. Once a write reaches the read side, empty falls on an rclk falling edge.
- R7: half_full is updated on each wclk rising edge and equals (write-side level >= 128).
- R8: almost_full is 1 exactly when the write-side level is at least 256 minus the almost-full offset. It rises on a wclk rising edge and falls on a wclk falling edge.
- R9: almost_empty is 1 exactly when the read-side level is at most the almost-empty offset. It rises on an rclk rising edge and falls on an rclk falling edge.
- R10: Both offsets are 8 after reset.
- R11: An offset load happens on a wclk rising edge with cfg_we high. cfg_sel 0 loads both offsets: almost-full from cfg_data[15:8] and almost-empty from cfg_data[7:0]. cfg_sel 1 loads only almost-full, from cfg_data[7:0]. cfg_sel 2 loads only almost-empty, from cfg_data[7:0]. cfg_sel 3 changes nothing. In the single-offset modes, cfg_data[15:8] is ignored.
- R12: Each pointer that crosses a clock boundary is Gray coded and changes by at most one bit per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset, released separately in each domain |
| wr_en | input | 1 | Push request, sampled on the wclk rising edge |
| wr_data | input | 36 | Word to push |
| full | output | 1 | Write-side level is 256 |
| almost_full | output | 1 | Write-side level is within the almost-full offset of the top |
| half_full | output | 1 | Write-side level is 128 or more |
| rd_en | input | 1 | Pop request, sampled on the rclk rising edge |
| rd_data | output | 36 | Registered word that was popped |
| empty | output | 1 | Read-side level is 0 |
| almost_empty | output | 1 | Read-side level is at or below the almost-empty offset |
| cfg_we | input | 1 | Offset load strobe, sampled on the wclk rising edge |
| cfg_sel | input | 2 | Offset load mode (see R11) |
| cfg_data | input | 16 | Offset load value |

## Verification
The bench runs complete fill-and-drain passes of all 256 words, each pass with a different data seed and a different pair of offsets. The offset pairs are the reset default, two values loaded one at a time, two values loaded together, both zero, and both 255. Each pass therefore places the almost-full and almost-empty thresholds somewhere else. It also tells the zero-offset case, in which those flags must match full and empty, apart from the widest-offset case. Pushes made after the FIFO is full carry different data, and a pop made while it is empty is followed by a single push. Both show whether a dropped access moved a pointer. Two watch loops sample the flags just after each rising edge and just after each falling edge, so the bench can tell which edge cleared full and empty.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;

  // Offset load modes selected by cfg_sel
  typedef enum logic [1:0] {
    CFG_BOTH = 2'd0,
    CFG_AF   = 2'd1,
    CFG_AE   = 2'd2,
    CFG_NONE = 2'd3
  } cfg_mode_e;

endpackage

// File: rtl/dcfifo_rst_sync.sv
module dcfifo_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 2'b00;
    else        stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_sync_n = stg_q[1];

endmodule

// File: rtl/dcfifo_sync.sv
module dcfifo_sync #(
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] nxt,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] s1_q;
  logic [WIDTH-1:0] s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  // nxt is the value q takes at the coming edge
  assign nxt = s1_q;
  assign q   = s2_q;

endmodule

// File: rtl/dcfifo_edge_flag.sv
module dcfifo_edge_flag #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_c,
  input  logic keep_c,
  output logic flag
);

  logic rise_t;
  logic fall_t;

  // Rising edge may only set the flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              rise_t <= RST_VAL;
    else if (!flag && set_c) rise_t <= ~rise_t;
  end

  // Falling edge may only clear the flag
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)               fall_t <= 1'b0;
    else if (flag && !keep_c) fall_t <= ~fall_t;
  end

  assign flag = rise_t ^ fall_t;

endmodule

// File: rtl/dcfifo_flags.sv
module dcfifo_flags #(
  parameter int DATA_W  = 36,
  parameter int ADDR_W  = 8,
  parameter int OFS_RST = 8
) (
  input  logic                wclk,
  input  logic                rclk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [DATA_W-1:0]   wr_data,
  output logic                full,
  output logic                almost_full,
  output logic                half_full,
  input  logic                rd_en,
  output logic [DATA_W-1:0]   rd_data,
  output logic                empty,
  output logic                almost_empty,
  input  logic                cfg_we,
  input  logic [1:0]          cfg_sel,
  input  logic [2*ADDR_W-1:0] cfg_data
);

  import dcfifo_pkg::*;

  localparam int PTR_W = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int OFS_W = ADDR_W;
  localparam logic [PTR_W-1:0] LVL_FULL = PTR_W'(DEPTH);
  localparam logic [PTR_W-1:0] LVL_HALF = PTR_W'(DEPTH / 2);

  function automatic logic [PTR_W-1:0] g2b(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // ---------------- resets ----------------
  logic wrst_n, rrst_n;

  dcfifo_rst_sync u_wrst (.clk(wclk), .rst_n(rst_n), .rst_sync_n(wrst_n));
  dcfifo_rst_sync u_rrst (.clk(rclk), .rst_n(rst_n), .rst_sync_n(rrst_n));

  // ---------------- storage ----------------
  logic [DATA_W-1:0] mem [DEPTH];

  // ---------------- write domain ----------------
  logic [PTR_W-1:0] wbin, wbin_d, wgray, wgray_d;
  logic [PTR_W-1:0] rg_q, rg_nxt, rb_q, rb_nxt;
  logic [PTR_W-1:0] wlevel, wlevel_d, af_lim, af_lim_d;
  logic [OFS_W-1:0] af_q, af_d, ae_q, ae_d;
  logic             wr_ok, hf_q;

  dcfifo_sync #(.WIDTH(PTR_W)) u_rg2w (
    .clk(wclk), .rst_n(wrst_n), .d(rgray_q), .nxt(rg_nxt), .q(rg_q)
  );

  always_comb begin
    rb_q     = g2b(rg_q);
    rb_nxt   = g2b(rg_nxt);
    wlevel   = wbin - rb_q;
    wr_ok    = wr_en && (wlevel != LVL_FULL);
    wbin_d   = wbin + PTR_W'(wr_ok);
    wgray_d  = wbin_d ^ (wbin_d >> 1);
    wlevel_d = wbin_d - rb_nxt;
    af_d     = af_q;
    ae_d     = ae_q;
    if (cfg_we) begin
      case (cfg_mode_e'(cfg_sel))
        CFG_BOTH: begin
          ae_d = cfg_data[OFS_W-1:0];
          af_d = cfg_data[2*OFS_W-1:OFS_W];
        end
        CFG_AF:   af_d = cfg_data[OFS_W-1:0];
        CFG_AE:   ae_d = cfg_data[OFS_W-1:0];
        CFG_NONE: ;
      endcase
    end
    af_lim   = LVL_FULL - PTR_W'(af_q);
    af_lim_d = LVL_FULL - PTR_W'(af_d);
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin  <= '0;
      wgray <= '0;
      af_q  <= OFS_W'(OFS_RST);
      ae_q  <= OFS_W'(OFS_RST);
      hf_q  <= 1'b0;
    end else begin
      wbin  <= wbin_d;
      wgray <= wgray_d;
      af_q  <= af_d;
      ae_q  <= ae_d;
      hf_q  <= (wlevel_d >= LVL_HALF);
    end
  end

  always_ff @(posedge wclk) begin
    if (wr_ok) mem[wbin[ADDR_W-1:0]] <= wr_data;
  end

  dcfifo_edge_flag #(.RST_VAL(1'b0)) u_full (
    .clk(wclk), .rst_n(wrst_n),
    .set_c(wlevel_d == LVL_FULL), .keep_c(wlevel == LVL_FULL), .flag(full)
  );

  dcfifo_edge_flag #(.RST_VAL(1'b0)) u_afull (
    .clk(wclk), .rst_n(wrst_n),
    .set_c(wlevel_d >= af_lim_d), .keep_c(wlevel >= af_lim), .flag(almost_full)
  );

  assign half_full = hf_q;

  // ---------------- read domain ----------------
  logic [PTR_W-1:0]  rbin, rbin_d, rgray_q, rgray_d;
  logic [PTR_W-1:0]  wg_q, wg_nxt, wb_q, wb_nxt;
  logic [PTR_W-1:0]  rlevel, rlevel_d;
  logic [OFS_W-1:0]  ae_rq, ae_rnxt;
  logic [DATA_W-1:0] rdata_q;
  logic              rd_ok;

  dcfifo_sync #(.WIDTH(PTR_W)) u_wg2r (
    .clk(rclk), .rst_n(rrst_n), .d(wgray), .nxt(wg_nxt), .q(wg_q)
  );

  // Offset is quasi-static: only changed while no traffic flows
  dcfifo_sync #(.WIDTH(OFS_W)) u_ae2r (
    .clk(rclk), .rst_n(rrst_n), .d(ae_q), .nxt(ae_rnxt), .q(ae_rq)
  );

  always_comb begin
    wb_q     = g2b(wg_q);
    wb_nxt   = g2b(wg_nxt);
    rlevel   = wb_q - rbin;
    rd_ok    = rd_en && (rlevel != '0);
    rbin_d   = rbin + PTR_W'(rd_ok);
    rgray_d  = rbin_d ^ (rbin_d >> 1);
    rlevel_d = wb_nxt - rbin_d;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin    <= '0;
      rgray_q <= '0;
      rdata_q <= '0;
    end else begin
      rbin    <= rbin_d;
      rgray_q <= rgray_d;
      if (rd_ok) rdata_q <= mem[rbin[ADDR_W-1:0]];
    end
  end

  dcfifo_edge_flag #(.RST_VAL(1'b1)) u_empty (
    .clk(rclk), .rst_n(rrst_n),
    .set_c(rlevel_d == '0), .keep_c(rlevel == '0), .flag(empty)
  );

  dcfifo_edge_flag #(.RST_VAL(1'b1)) u_aempty (
    .clk(rclk), .rst_n(rrst_n),
    .set_c(rlevel_d <= PTR_W'(ae_rnxt)), .keep_c(rlevel <= PTR_W'(ae_rq)),
    .flag(almost_empty)
  );

  assign rd_data = rdata_q;

  // ---------------- assertions ----------------
  p_full_match_r5: assert property (@(posedge wclk) disable iff (!wrst_n)
    full == (wlevel == LVL_FULL));

  p_half_match_r7: assert property (@(posedge wclk) disable iff (!wrst_n)
    half_full == (wlevel >= LVL_HALF));

  p_no_overflow_r3: assert property (@(posedge wclk) disable iff (!wrst_n)
    (wr_en && full) |=> $stable(wbin));

  p_wgray_step_r12: assert property (@(posedge wclk) disable iff (!wrst_n)
    $countones(wgray ^ $past(wgray)) <= 1);

  p_empty_match_r6: assert property (@(posedge rclk) disable iff (!rrst_n)
    empty == (rlevel == '0));

  p_no_underflow_r4: assert property (@(posedge rclk) disable iff (!rrst_n)
    (rd_en && empty) |=> ($stable(rbin) && $stable(rd_data)));

  p_rgray_step_r12: assert property (@(posedge rclk) disable iff (!rrst_n)
    $countones(rgray_q ^ $past(rgray_q)) <= 1);

endmodule

// File: tb/dcfifo_flags_test.sv
module dcfifo_flags_test;

  import dcfifo_pkg::*;

  localparam int CLK_PERIOD  = 10;
  localparam int RCLK_PERIOD = 14;
  localparam int DATA_W      = 36;
  localparam int ADDR_W      = 8;
  localparam int DEPTH       = 1 << ADDR_W;

  logic              wclk, rclk, rst_n;
  logic              wr_en, rd_en, cfg_we;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic [1:0]        cfg_sel;
  logic [15:0]       cfg_data;
  logic              full, almost_full, half_full, empty, almost_empty;

  int n_chk = 0;
  int n_err = 0;
  int lvl   = 0;
  int af_m  = 8;
  int ae_m  = 8;

  dcfifo_flags uut (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_data(wr_data),
    .full(full), .almost_full(almost_full), .half_full(half_full),
    .rd_en(rd_en), .rd_data(rd_data),
    .empty(empty), .almost_empty(almost_empty),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data)
  );

  initial begin
    wclk = 1'b0;
    forever #(CLK_PERIOD / 2) wclk = ~wclk;
  end

  initial begin
    rclk = 1'b0;
    forever #(RCLK_PERIOD / 2) rclk = ~rclk;
  end

  function automatic logic [DATA_W-1:0] pat(input int seed, input int i);
    return {4'(seed), 24'(i * 40503 + seed * 977), 8'(i)};
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  task automatic wr_one(input logic [DATA_W-1:0] d);
    @(negedge wclk);
    wr_en   = 1'b1;
    wr_data = d;
    @(posedge wclk);
    #1;
    wr_en = 1'b0;
  endtask

  task automatic rd_one;
    @(negedge rclk);
    rd_en = 1'b1;
    @(posedge rclk);
    #1;
    rd_en = 1'b0;
  endtask

  task automatic settle;
    repeat (6) @(posedge rclk);
    repeat (6) @(posedge wclk);
    #1;
  endtask

  task automatic cfg_wr(input logic [1:0] sel, input logic [15:0] d);
    @(negedge wclk);
    cfg_we   = 1'b1;
    cfg_sel  = sel;
    cfg_data = d;
    @(posedge wclk);
    #1;
    cfg_we = 1'b0;
  endtask

  // Write-side flags checked right after each rising edge
  task automatic fill(input int n, input int seed, input int start);
    for (int i = 0; i < n; i++) begin
      wr_one(pat(seed, start + i));
      if (lvl < DEPTH) lvl++;
      check(full == (lvl == DEPTH), "R5 full", full, (lvl == DEPTH));
      check(half_full == (lvl >= DEPTH / 2), "R7 half_full", half_full, (lvl >= DEPTH / 2));
      check(almost_full == (lvl >= DEPTH - af_m), "R8/R10/R11 almost_full",
            almost_full, (lvl >= DEPTH - af_m));
    end
  endtask

  // Read data and read-side flags checked right after each rising edge
  task automatic drain(input int n, input int seed, input int start);
    for (int j = 0; j < n; j++) begin
      rd_one;
      lvl--;
      check(rd_data == pat(seed, start + j), "R2 R3 read order", rd_data, pat(seed, start + j));
      check(empty == (lvl == 0), "R6 empty", empty, (lvl == 0));
      check(almost_empty == (lvl <= ae_m), "R9/R10/R11 almost_empty",
            almost_empty, (lvl <= ae_m));
    end
  endtask

  task automatic watch_full_fall;
    bit at_pos = 0;
    bit at_neg = 0;
    for (int k = 0; k < 20 && !at_pos && !at_neg; k++) begin
      @(posedge wclk); #1;
      if (!full) at_pos = 1;
      else begin
        @(negedge wclk); #1;
        if (!full) at_neg = 1;
      end
    end
    check(at_neg && !at_pos, "R5 full clears on wclk falling edge", {at_pos, at_neg}, 2'b01);
  endtask

  task automatic watch_empty_fall;
    bit at_pos = 0;
    bit at_neg = 0;
    for (int k = 0; k < 20 && !at_pos && !at_neg; k++) begin
      @(posedge rclk); #1;
      if (!empty) at_pos = 1;
      else begin
        @(negedge rclk); #1;
        if (!empty) at_neg = 1;
      end
    end
    check(at_neg && !at_pos, "R6 empty clears on rclk falling edge", {at_pos, at_neg}, 2'b01);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run;
  end

  initial begin
    logic [DATA_W-1:0] prev;
    rst_n    = 1'b0;
    wr_en    = 1'b0;
    rd_en    = 1'b0;
    cfg_we   = 1'b0;
    cfg_sel  = 2'd0;
    cfg_data = '0;
    wr_data  = '0;
    repeat (4) @(posedge wclk);
    @(negedge wclk);
    rst_n = 1'b1;
    settle;

    // R1 reset state
    check(empty == 1'b1, "R1 empty", empty, 1);
    check(almost_empty == 1'b1, "R1 almost_empty", almost_empty, 1);
    check(full == 1'b0, "R1 full", full, 0);
    check(almost_full == 1'b0, "R1 almost_full", almost_full, 0);
    check(half_full == 1'b0, "R1 half_full", half_full, 0);
    check(rd_data == '0, "R1 rd_data", rd_data, 0);

    // Pass A: default offsets (R10), three extra pushes while full (R3)
    fill(DEPTH + 3, 1, 0);
    settle;
    check(empty == 1'b0, "R6 empty low after fill", empty, 0);
    check(almost_empty == 1'b0, "R9 almost_empty low after fill", almost_empty, 0);
    drain(1, 1, 0);
    watch_full_fall;
    check(almost_full == 1'b1, "R8 almost_full held at level 255", almost_full, 1);
    drain(DEPTH - 1, 1, 1);

    // R4: pop while empty is dropped
    prev = rd_data;
    rd_one;
    check(rd_data == prev, "R4 rd_data held on empty pop", rd_data, prev);
    check(empty == 1'b1, "R4 empty stays high", empty, 1);
    wr_one(pat(7, 0));
    lvl = 1;
    watch_empty_fall;
    settle;
    rd_one;
    lvl = 0;
    check(rd_data == pat(7, 0), "R4 read position unmoved", rd_data, pat(7, 0));
    check(empty == 1'b1, "R6 empty after single word", empty, 1);
    settle;

    // Pass B: single-offset loads, upper byte and mode 3 ignored (R11)
    cfg_wr(CFG_AF, 16'hFF14);
    cfg_wr(CFG_AE, 16'hEE03);
    cfg_wr(CFG_NONE, 16'h0101);
    af_m = 20;
    ae_m = 3;
    settle;
    fill(4, 2, 0);
    settle;
    check(almost_empty == 1'b0, "R11 single ae load at level 4", almost_empty, 0);
    fill(DEPTH - 4, 2, 4);
    settle;
    drain(DEPTH, 2, 0);
    settle;

    // Pass C: both offsets in one load (R11)
    cfg_wr(CFG_BOTH, {8'd100, 8'd50});
    af_m = 100;
    ae_m = 50;
    settle;
    fill(DEPTH, 3, 0);
    settle;
    drain(DEPTH, 3, 0);
    settle;

    // Pass D: zero offsets track full and empty
    cfg_wr(CFG_BOTH, 16'h0000);
    af_m = 0;
    ae_m = 0;
    settle;
    check(almost_empty == 1'b1, "R9 zero offset at level 0", almost_empty, 1);
    fill(DEPTH, 4, 0);
    settle;
    drain(DEPTH, 4, 0);
    settle;

    // Pass E: widest offsets
    cfg_wr(CFG_BOTH, 16'hFFFF);
    af_m = 255;
    ae_m = 255;
    settle;
    fill(DEPTH, 5, 0);
    settle;
    drain(DEPTH, 5, 0);
    settle;

    finish_run;
  end

endmodule